// File: doc/BRIEF.md
# Dual-Mode Host Parallel Bus Port

This block is the 8-bit control port through which a host processor reads and writes four per-channel register banks. Each bank holds 32 eight-bit registers. The port is modelled synchronously to a system clock. Strobe edges are found by comparing each input sample with the sample from the cycle before.

Two static inputs configure the port. `mux_sel` chooses between a shared address/data bus and a separate 5-bit address bus. `bus_style` chooses between split read and write strobes and a data strobe paired with a read/write level. Four active-low chip selects pick the banks that take part in an access. A float request disables the transmit line drivers. When any chip select is also active, the float request additionally releases the data bus and the interrupt line. In each bank, register 31 is an interrupt mask and address 30 reads back that channel's live status inputs. The open-drain interrupt is pulled whenever any status bit meets a set mask bit.

Accesses are tracked by a four-state machine:
- ST_IDLE goes to ST_READ when a read is active with a chip select. This check comes first.
- Otherwise, ST_IDLE goes to ST_WRITE when a write is active with a chip select.
- ST_WRITE returns to ST_IDLE when the write strobe ends, and the write commits in that cycle.
- ST_READ returns to ST_IDLE when the read ends and no write is active.
- ST_READ goes to ST_DRAIN when the read ends while a write is active.
- ST_DRAIN returns to ST_IDLE once both strobes are inactive.

Top module: `hostbus_port`

## Requirements
- R1: While `rst_n` is low, every register of every bank is cleared to 0. After reset, reads return 0, `data_oe` is low and `irq_pull` is low.
- R2: With `mux_sel`=1 the register address is taken from `addr_i`, and `ale_i` has no effect.
- R3: With `mux_sel`=0 the register address is `data_i[4:0]`, captured in the cycle where `ale_i` is seen rising. In this mode `addr_i` has no effect.
- R4: With `bus_style`=0, `rd_n` low is a read and `wr_n` low is a write. A write commits when `wr_n` returns high. The committed value is the `data_i` seen in the last cycle that `wr_n` was low.
- R5: With `bus_style`=1, `rd_n` is a data strobe. `wr_n` high while the strobe is low means a read, and `wr_n` low means a write. A write commits when `rd_n` returns high, using the last data seen while the strobe was low.
- R6: `cs_n[i]` low selects bank i. A write goes to every selected bank. A read returns the lowest-numbered selected bank. With no chip select low, no register changes.
- R7: `data_oe` is high only while a read is active, at least one chip select is low and `float_req` is low.
- R8: When `float_req` is high, `line_oe` is low. When `float_req` is high and any chip select is low, `data_oe` and `irq_pull` are also low.
- R9: Reading address 30 returns that channel's 8 status bits from `stat_i[8*i +: 8]`. Address 31 holds that channel's interrupt mask. `irq_pull` is high when any channel has a status bit and a mask bit set at the same position.
- R10: A write strobe that becomes active during a read does not commit. With `bus_style`=0, if both strobes go low together the access is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| mux_sel | input | 1 | 0: shared address/data bus, 1: separate address bus |
| bus_style | input | 1 | 0: split read/write strobes, 1: data strobe plus read/write level |
| float_req | input | 1 | Float request for the line drivers, or for all outputs when selected |
| cs_n | input | 4 | Active-low per-bank chip selects |
| rd_n | input | 1 | Read strobe, or data strobe when `bus_style`=1 |
| wr_n | input | 1 | Write strobe, or read/write level when `bus_style`=1 |
| ale_i | input | 1 | Address latch strobe (used when `mux_sel`=0) |
| addr_i | input | 5 | Separate register address |
| data_i | input | 8 | Bus value arriving from the host |
| data_o | output | 8 | Read data |
| data_oe | output | 1 | Data bus drive enable |
| stat_i | input | 32 | Status bits, 8 per channel |
| line_oe | output | 1 | Transmit line driver enable |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
If the state machine is left in the wrong state, a later write either fails to commit or commits when it should not. This shows up at the very next read-back, within a few cycles. A wrong latched address or wrong chip-select capture puts data in the wrong bank or register. Reads of both the target and its neighbours expose this in the next access. A wrong mask or status path changes `irq_pull` in the same cycle that the status inputs change.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DRAIN = 2'd3
    } bus_st_t;
endpackage

// File: rtl/hbp_strobe.sv
module hbp_strobe (
    input  logic bus_style,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_act,
    output logic wr_act
);
    always_comb begin
        if (bus_style) begin
            rd_act = !rd_n && wr_n;
            wr_act = !rd_n && !wr_n;
        end else begin
            rd_act = !rd_n;
            wr_act = !wr_n;
        end
    end
endmodule

// File: rtl/hbp_addr.sv
module hbp_addr #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_sel,
    input  logic          ale_i,
    input  logic [AW-1:0] bus_lo,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] lat_addr,
    output logic [AW-1:0] eff_addr
);
    logic ale_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q    <= 1'b0;
            lat_addr <= '0;
        end else begin
            ale_q <= ale_i;
            if (!mux_sel && ale_i && !ale_q)
                lat_addr <= bus_lo;
        end
    end

    assign eff_addr = mux_sel ? addr_i : lat_addr;
endmodule

// File: rtl/hbp_bank.sv
module hbp_bank #(
    parameter int DW        = 8,
    parameter int AW        = 5,
    parameter int STAT_ADDR = 30,
    parameter int MASK_ADDR = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    input  logic [DW-1:0] stat,
    output logic [DW-1:0] rdata,
    output logic          irq_hit
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++)
                mem[k] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata   = (raddr == AW'(STAT_ADDR)) ? stat : mem[raddr];
    assign irq_hit = |(stat & mem[AW'(MASK_ADDR)]);
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port #(
    parameter int NCH       = 4,
    parameter int DW        = 8,
    parameter int AW        = 5,
    parameter int STAT_ADDR = 30,
    parameter int MASK_ADDR = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_sel,
    input  logic              bus_style,
    input  logic              float_req,
    input  logic [NCH-1:0]    cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              ale_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     data_i,
    output logic [DW-1:0]     data_o,
    output logic              data_oe,
    input  logic [NCH*DW-1:0] stat_i,
    output logic              line_oe,
    output logic              irq_pull
);
    import hbp_pkg::*;

    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    bus_st_t        state_q, state_d;
    logic           rd_act, wr_act, cs_any, float_all, commit;
    logic [AW-1:0]  lat_addr, eff_addr, waddr_q;
    logic [DW-1:0]  wdat_q;
    logic [NCH-1:0] wcs_q, bank_we, irq_hit;
    logic [DW-1:0]  bank_rd [NCH];
    logic [CW-1:0]  rd_ch;

    hbp_strobe u_strobe (
        .bus_style (bus_style),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rd_act    (rd_act),
        .wr_act    (wr_act)
    );

    hbp_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mux_sel  (mux_sel),
        .ale_i    (ale_i),
        .bus_lo   (data_i[AW-1:0]),
        .addr_i   (addr_i),
        .lat_addr (lat_addr),
        .eff_addr (eff_addr)
    );

    assign cs_any = |(~cs_n);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_any && rd_act)      state_d = ST_READ;
                else if (cs_any && wr_act) state_d = ST_WRITE;
            end
            ST_READ: begin
                if (!rd_act) state_d = wr_act ? ST_DRAIN : ST_IDLE;
            end
            ST_WRITE: begin
                if (!wr_act) state_d = ST_IDLE;
            end
            ST_DRAIN: begin
                if (!rd_act && !wr_act) state_d = ST_IDLE;
            end
        endcase
    end

    // Write capture: target banks and address held from strobe start, data tracked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcs_q   <= '0;
            waddr_q <= '0;
            wdat_q  <= '0;
        end else if (state_q == ST_IDLE && state_d == ST_WRITE) begin
            wcs_q   <= ~cs_n;
            waddr_q <= eff_addr;
            wdat_q  <= data_i;
        end else if (state_q == ST_WRITE && wr_act) begin
            wdat_q  <= data_i;
        end
    end

    assign commit  = (state_q == ST_WRITE) && !wr_act;
    assign bank_we = commit ? wcs_q : '0;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_bank
            hbp_bank #(
                .DW(DW), .AW(AW), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .we      (bank_we[gi]),
                .waddr   (waddr_q),
                .wdata   (wdat_q),
                .raddr   (eff_addr),
                .stat    (stat_i[gi*DW +: DW]),
                .rdata   (bank_rd[gi]),
                .irq_hit (irq_hit[gi])
            );
        end
    endgenerate

    // Output logic: lowest selected bank feeds the bus
    always_comb begin
        rd_ch = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (!cs_n[i]) rd_ch = CW'(i);
    end

    assign float_all = float_req && cs_any;
    assign data_o    = bank_rd[rd_ch];
    assign data_oe   = rd_act && cs_any && !float_req;
    assign line_oe   = !float_req;
    assign irq_pull  = (|irq_hit) && !float_all;
endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk #(
    parameter int NCH = 4,
    parameter int AW  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mux_sel,
    input logic           float_req,
    input logic [NCH-1:0] cs_n,
    input logic           rd_n,
    input logic           ale_i,
    input logic           data_oe,
    input logic           irq_pull,
    input logic [AW-1:0]  lat_addr,
    input logic [1:0]     st,
    input logic [NCH-1:0] bank_we
);
    import hbp_pkg::*;

    // R7
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!rd_n && cs_n != '1 && !float_req));

    // R8
    float_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (float_req && cs_n != '1) |-> (!data_oe && !irq_pull));

    // R3
    ale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel || !ale_i) |=> $stable(lat_addr));

    // R10
    commit_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we != '0) |-> (st == ST_WRITE));

    // R6
    no_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cs_n == '1) |=> (st == ST_IDLE));
endmodule

bind hostbus_port hostbus_port_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mux_sel   (mux_sel),
    .float_req (float_req),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .ale_i     (ale_i),
    .data_oe   (data_oe),
    .irq_pull  (irq_pull),
    .lat_addr  (lat_addr),
    .st        (state_q),
    .bank_we   (bank_we)
);

// File: tb/hostbus_port_tb_top.sv
`timescale 1ns/1ps
module hostbus_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mux_sel = 1'b1;
    logic        bus_style = 1'b0;
    logic        float_req = 1'b0;
    logic [3:0]  cs_n = 4'hF;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ale_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  data_o;
    logic        data_oe;
    logic [31:0] stat_i = '0;
    logic        line_oe;
    logic        irq_pull;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hostbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .bus_style(bus_style),
        .float_req(float_req), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ale_i(ale_i), .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
        .data_oe(data_oe), .stat_i(stat_i), .line_oe(line_oe), .irq_pull(irq_pull)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_addr(input logic [4:0] a);
        @(negedge clk);
        if (!mux_sel) begin
            data_i = {3'b000, a};
            addr_i = ~a;
        end else begin
            addr_i = a;
            data_i = {3'b000, ~a};
        end
        ale_i = 1'b1;
        @(negedge clk);
        ale_i  = 1'b0;
        data_i = 8'h00;
    endtask

    task automatic bus_write(input logic [3:0] csn, input logic [4:0] a, input logic [7:0] d);
        set_addr(a);
        @(negedge clk);
        cs_n   = csn;
        data_i = ~d;
        wr_n   = 1'b0;
        if (bus_style) rd_n = 1'b0;
        @(negedge clk);
        data_i = d;
        @(negedge clk);
        if (bus_style) rd_n = 1'b1;
        else           wr_n = 1'b1;
        @(negedge clk);
        wr_n   = 1'b1;
        cs_n   = 4'hF;
        data_i = 8'h00;
    endtask

    task automatic bus_read(input logic [3:0] csn, input logic [4:0] a,
                            output logic [7:0] d, output logic oe);
        set_addr(a);
        @(negedge clk);
        cs_n = csn;
        wr_n = 1'b1;
        rd_n = 1'b0;
        #1;
        d  = data_o;
        oe = data_oe;
        @(negedge clk);
        rd_n = 1'b1;
        cs_n = 4'hF;
    endtask

    task automatic t_reset_state;
        logic [7:0] d; logic oe;
        #1;
        chk("R1 idle data_oe", {7'd0, data_oe}, 8'h00);
        chk("R1 irq_pull", {7'd0, irq_pull}, 8'h00);
        bus_read(4'b1110, 5'd5, d, oe);
        chk("R1 reg clear after reset", d, 8'h00);
    endtask

    task automatic t_intel_sep;
        logic [7:0] d; logic oe;
        mux_sel = 1'b1; bus_style = 1'b0;
        bus_write(4'b1110, 5'd3, 8'hA5);
        bus_read(4'b1110, 5'd3, d, oe);
        chk("R4 split-strobe write/read", d, 8'hA5);
        chk("R2 separate address", d, 8'hA5);
        chk("R7 drive during read", {7'd0, oe}, 8'h01);
        #1;
        chk("R7 released after read", {7'd0, data_oe}, 8'h00);
    endtask

    task automatic t_moto_sep;
        logic [7:0] d; logic oe;
        mux_sel = 1'b1; bus_style = 1'b1;
        @(negedge clk);
        cs_n = 4'b1101; addr_i = 5'd7; wr_n = 1'b0; rd_n = 1'b0; data_i = 8'h3C;
        #1;
        chk("R5 no drive during data-strobe write", {7'd0, data_oe}, 8'h00);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 4'hF;
        bus_read(4'b1101, 5'd7, d, oe);
        chk("R5 data-strobe write/read", d, 8'h3C);
        bus_write(4'b1101, 5'd8, 8'hC7);
        bus_read(4'b1101, 5'd8, d, oe);
        chk("R5 last data before strobe end", d, 8'hC7);
        bus_style = 1'b0;
    endtask

    task automatic t_mux;
        logic [7:0] d; logic oe;
        mux_sel = 1'b0;
        bus_write(4'b1011, 5'd17, 8'h5A);
        bus_read(4'b1011, 5'd17, d, oe);
        chk("R3 multiplexed write/read", d, 8'h5A);
        mux_sel = 1'b1;
        bus_read(4'b1011, 5'd17, d, oe);
        chk("R3 latched address landed", d, 8'h5A);
        bus_read(4'b1011, 5'd14, d, oe);
        chk("R3 addr_i ignored in mux mode", d, 8'h00);
    endtask

    task automatic t_cs;
        logic [7:0] d; logic oe;
        mux_sel = 1'b1; bus_style = 1'b0;
        bus_write(4'b1001, 5'd9, 8'h77);
        bus_write(4'b0111, 5'd9, 8'h11);
        bus_read(4'b1101, 5'd9, d, oe);
        chk("R6 bank1 multi-select write", d, 8'h77);
        bus_read(4'b1011, 5'd9, d, oe);
        chk("R6 bank2 multi-select write", d, 8'h77);
        bus_read(4'b1110, 5'd9, d, oe);
        chk("R6 bank0 untouched", d, 8'h00);
        bus_read(4'b0111, 5'd9, d, oe);
        chk("R6 bank3 own write", d, 8'h11);
        bus_read(4'b0011, 5'd9, d, oe);
        chk("R6 lowest selected wins", d, 8'h77);
        bus_write(4'b1111, 5'd9, 8'h99);
        bus_read(4'b1101, 5'd9, d, oe);
        chk("R6 no-select write ignored", d, 8'h77);
        bus_read(4'b1111, 5'd9, d, oe);
        chk("R7 no drive without select", {7'd0, oe}, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] d; logic oe;
        bus_write(4'b1011, 5'd31, 8'h04);
        @(negedge clk);
        stat_i = 32'h0004_0000;
        #1;
        chk("R9 irq on masked status", {7'd0, irq_pull}, 8'h01);
        @(negedge clk);
        stat_i = 32'h0002_0000;
        #1;
        chk("R9 irq off for unmasked status", {7'd0, irq_pull}, 8'h00);
        bus_read(4'b1011, 5'd30, d, oe);
        chk("R9 status read", d, 8'h02);
        bus_write(4'b1110, 5'd30, 8'hFF);
        bus_read(4'b1110, 5'd30, d, oe);
        chk("R9 status address shows live bits", d, 8'h00);
        @(negedge clk);
        stat_i = 32'h0004_0000;
    endtask

    task automatic t_float;
        @(negedge clk);
        float_req = 1'b1;
        #1;
        chk("R8 line float", {7'd0, line_oe}, 8'h00);
        chk("R8 irq kept without select", {7'd0, irq_pull}, 8'h01);
        @(negedge clk);
        cs_n = 4'b1011; rd_n = 1'b0;
        #1;
        chk("R8 data floated", {7'd0, data_oe}, 8'h00);
        chk("R8 irq floated", {7'd0, irq_pull}, 8'h00);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 4'hF; float_req = 1'b0;
        #1;
        chk("R8 line restored", {7'd0, line_oe}, 8'h01);
    endtask

    task automatic t_drain;
        logic [7:0] d; logic oe;
        mux_sel = 1'b1; bus_style = 1'b0;
        @(negedge clk);
        cs_n = 4'b1110; addr_i = 5'd4; data_i = 8'hEE; rd_n = 1'b0; wr_n = 1'b0;
        #1;
        chk("R10 read wins on both strobes", {7'd0, data_oe}, 8'h01);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 4'hF;
        bus_read(4'b1110, 5'd4, d, oe);
        chk("R10 overlapping write not committed", d, 8'h00);
    endtask

    task automatic t_reset_clear;
        logic [7:0] d; logic oe;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq after reset (mask cleared)", {7'd0, irq_pull}, 8'h00);
        bus_read(4'b1011, 5'd31, d, oe);
        chk("R1 mask cleared", d, 8'h00);
        bus_read(4'b1110, 5'd3, d, oe);
        chk("R1 data reg cleared", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_intel_sep();
        t_moto_sep();
        t_mux();
        t_cs();
        t_irq();
        t_float();
        t_drain();
        t_reset_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule